// File: doc/BRIEF.md
# Hopping Code Regenerator

This block rebuilds, inside a frequency-hopping receiver, the pseudorandom hop code that the transmitter used. It takes two single-bit signals that earlier receive logic has already recovered. The first is a square carrier. The second is a demodulated length signal, whose transitions mark the code boundaries. The output is a 4-bit code word for the local oscillators, with a one-cycle strobe each time the word is updated.

Carrier rising edges advance a six-phase state machine. The machine reports a chip-rate enable each time it comes back to its first phase, so a 9 MHz carrier gives a 1.5 MHz chip rate. Any transition of the length signal gives a one-cycle reload pulse. Both pulses pass through the same five-stage alignment delay. They then drive a 5-bit shift register with feedback from x^5 + x^3 + 1. A reload sets the register to all ones. An enable shifts it one step. The register's upper four bits form the code.

The phase machine has states PH0 to PH5 and resets to PH0. On a cycle with a carrier rising edge, PH0 moves to PH1, PH1 to PH2, PH2 to PH3, PH3 to PH4, PH4 to PH5, and PH5 wraps to PH0. On any other cycle every state holds.

Top module: `hop_code_regen`

## Requirements
- R1: While rst is high and on the first cycle after it, code_o reads 4'b1111 and code_valid_o is 0.
- R2: One chip enable follows each group of six carrier rising edges, counted from reset. With a steady carrier period of P clocks, the code_valid_o pulses that enables cause are exactly 6*P clocks apart.
- R3: Each rising edge and each falling edge of length_i causes one reload. While length_i holds its level, no reload occurs.
- R4: A reload sets the 5-bit register to 5'b11111, so code_o reads 4'b1111.
- R5: A length_i change first seen in clock cycle t gives code_valid_o high in cycle t+6, and not before. A carrier rising edge that completes a group of six gives code_valid_o high in cycle t+7. The extra cycle comes from the phase machine register.
- R6: An enable shifts the register s to {s[3:0], s[4]^s[2]}. code_o is s[4:1]. Starting from all ones, the register returns to all ones after 31 enables.
- R7: When a reload and an enable reach the register in the same cycle, the reload wins and code_o reads 4'b1111.
- R8: code_valid_o is high for exactly one cycle after each register update. code_o changes only in a cycle where code_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| carrier_i | input | 1 | Recovered square carrier |
| length_i | input | 1 | Demodulated length signal; its edges mark code boundaries |
| code_o | output | 4 | Recovered hop code (register bits 4 to 1) |
| code_valid_o | output | 1 | One-cycle strobe when code_o is updated |

## Verification
The hardest case to reach is a reload and a chip enable arriving at the register in the same cycle. The enable position depends on how many carrier edges have been seen since reset. The bench runs its behavioural model alongside the design, and in the cycle where the model predicts a chip enable it toggles length_i. Both pulses then enter the alignment delay together. The bench also runs 31 chip enables after a reload to confirm that the full sequence and its period match, and it varies the carrier period randomly, adding occasional length edges and a reset.

// File: rtl/hop_pkg.sv
package hop_pkg;
    typedef enum logic [2:0] {
        PH0 = 3'd0,
        PH1 = 3'd1,
        PH2 = 3'd2,
        PH3 = 3'd3,
        PH4 = 3'd4,
        PH5 = 3'd5
    } phase_t;

    localparam int PHASE_COUNT = 6;
endpackage

// File: rtl/chip_enable_gen.sv
module chip_enable_gen
    import hop_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic carrier_i,
    output logic chip_en
);
    logic   car_q;
    logic   car_rise;
    phase_t phase_q;
    phase_t phase_d;
    logic   at_zero;
    logic   zero_q;

    // The previous-carrier register follows the input during reset,
    // so no spurious edge appears when reset is released.
    always_ff @(posedge clk) begin
        car_q <= carrier_i;
    end

    assign car_rise = carrier_i & ~car_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH0;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH0: if (car_rise) phase_d = PH1;
            PH1: if (car_rise) phase_d = PH2;
            PH2: if (car_rise) phase_d = PH3;
            PH3: if (car_rise) phase_d = PH4;
            PH4: if (car_rise) phase_d = PH5;
            PH5: if (car_rise) phase_d = PH0;
            default: phase_d = PH0;
        endcase
    end

    assign at_zero = (phase_q == PH0);

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_q <= 1'b1;
        end else begin
            zero_q <= at_zero;
        end
    end

    assign chip_en = at_zero & ~zero_q;
endmodule

// File: rtl/load_pulse_gen.sv
module load_pulse_gen (
    input  logic clk,
    input  logic length_i,
    output logic load_pulse
);
    logic len_q;

    always_ff @(posedge clk) begin
        len_q <= length_i;
    end

    assign load_pulse = length_i ^ len_q;
endmodule

// File: rtl/pulse_delay.sv
module pulse_delay #(
    parameter int DEPTH = 5,
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (DEPTH <= 1) begin : g_single
            logic [WIDTH-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q <= '0;
                end else begin
                    stage_q <= d;
                end
            end
            assign q = stage_q;
        end else begin : g_chain
            logic [DEPTH-1:0][WIDTH-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q <= '0;
                end else begin
                    stage_q <= {stage_q[DEPTH-2:0], d};
                end
            end
            assign q = stage_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/lfsr_code.sv
module lfsr_code #(
    parameter int REG_W  = 5,
    parameter int CODE_W = 4,
    parameter int TAP    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reload,
    input  logic              step,
    output logic [CODE_W-1:0] code,
    output logic              valid
);
    localparam logic [REG_W-1:0] SEED = '1;

    logic [REG_W-1:0] state_q;
    logic             feedback;

    assign feedback = state_q[REG_W-1] ^ state_q[TAP];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
            valid   <= 1'b0;
        end else begin
            valid <= reload | step;
            if (reload) begin
                state_q <= SEED;
            end else if (step) begin
                state_q <= {state_q[REG_W-2:0], feedback};
            end
        end
    end

    assign code = state_q[REG_W-1 -: CODE_W];
endmodule

// File: rtl/hop_code_regen.sv
module hop_code_regen #(
    parameter int REG_W       = 5,
    parameter int CODE_W      = 4,
    parameter int ALIGN_DEPTH = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              carrier_i,
    input  logic              length_i,
    output logic [CODE_W-1:0] code_o,
    output logic              code_valid_o
);
    localparam int FB_TAP = REG_W - 3;

    logic       chip_en;
    logic       load_pulse;
    logic [1:0] ctl_dly;
    logic       ld_dly;
    logic       en_dly;

    chip_enable_gen u_enable (
        .clk       (clk),
        .rst       (rst),
        .carrier_i (carrier_i),
        .chip_en   (chip_en)
    );

    load_pulse_gen u_load (
        .clk        (clk),
        .length_i   (length_i),
        .load_pulse (load_pulse)
    );

    pulse_delay #(
        .DEPTH (ALIGN_DEPTH),
        .WIDTH (2)
    ) u_align (
        .clk (clk),
        .rst (rst),
        .d   ({load_pulse, chip_en}),
        .q   (ctl_dly)
    );

    assign ld_dly = ctl_dly[1];
    assign en_dly = ctl_dly[0];

    lfsr_code #(
        .REG_W  (REG_W),
        .CODE_W (CODE_W),
        .TAP    (FB_TAP)
    ) u_lfsr (
        .clk    (clk),
        .rst    (rst),
        .reload (ld_dly),
        .step   (en_dly),
        .code   (code_o),
        .valid  (code_valid_o)
    );
endmodule

// File: rtl/hop_code_regen_chk.sv
module hop_code_regen_chk (
    input logic       clk,
    input logic       rst,
    input logic       length_i,
    input logic [3:0] code_o,
    input logic       code_valid_o,
    input logic       chip_en,
    input logic       load_pulse,
    input logic       ld_dly,
    input logic       en_dly
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (code_o == 4'hF && !code_valid_o)); // R1

    AST_ENABLE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        chip_en |=> !chip_en); // R2

    AST_LOAD_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        load_pulse |-> (length_i != $past(length_i))); // R3

    AST_LOAD_SEED: assert property (@(posedge clk) disable iff (rst)
        $past(ld_dly) |-> (code_o == 4'hF && code_valid_o)); // R4 R7

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
        ($past(en_dly) && !$past(ld_dly)) |-> (code_o[3:1] == $past(code_o[2:0]) && code_valid_o)); // R6

    AST_HOLD_CODE: assert property (@(posedge clk) disable iff (rst)
        !code_valid_o |-> $stable(code_o)); // R8

    AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
        code_valid_o |-> $past(ld_dly || en_dly)); // R8
endmodule

bind hop_code_regen hop_code_regen_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .length_i     (length_i),
    .code_o       (code_o),
    .code_valid_o (code_valid_o),
    .chip_en      (chip_en),
    .load_pulse   (load_pulse),
    .ld_dly       (ld_dly),
    .en_dly       (en_dly)
);

// File: tb/hop_code_regen_tb.sv
module hop_code_regen_tb;
    localparam int CLK_NS = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       carrier = 1'b0;
    logic       length = 1'b0;
    logic [3:0] code;
    logic       valid;

    always #(CLK_NS / 2) clk = ~clk;

    hop_code_regen u_dut (
        .clk          (clk),
        .rst          (rst),
        .carrier_i    (carrier),
        .length_i     (length),
        .code_o       (code),
        .code_valid_o (valid)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    int cyc      = 0;

    // behavioural reference state
    int m_car_d  = 0;
    int m_cnt    = 0;
    int m_zero_d = 1;
    int m_len_d  = 0;
    int m_lfsr   = 31;
    int m_valid  = 0;
    int q_ld[$]  = '{0, 0, 0, 0, 0};
    int q_en[$]  = '{0, 0, 0, 0, 0};

    logic [3:0] obs_code;
    logic       obs_valid;

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int lfsr_next(int s);
        return ((s << 1) & 31) | (((s >> 4) ^ (s >> 2)) & 1);
    endfunction

    function automatic bit model_en_now();
        return (m_cnt == 0) && (m_zero_d == 0);
    endfunction

    task automatic step(bit c, bit l, bit r);
        int rise, zero, en, ld, ld_out, en_out;
        @(negedge clk);
        cyc++;
        obs_code  = code;
        obs_valid = valid;
        check(int'(obs_code) == (m_lfsr >> 1), "R8 per-cycle code", int'(obs_code), m_lfsr >> 1);
        check(int'(obs_valid) == m_valid, "R8 per-cycle strobe", int'(obs_valid), m_valid);
        carrier = c;
        length  = l;
        rst     = r;
        if (r) begin
            m_car_d = c; m_len_d = l; m_cnt = 0; m_zero_d = 1;
            m_lfsr = 31; m_valid = 0;
            q_ld = '{0, 0, 0, 0, 0};
            q_en = '{0, 0, 0, 0, 0};
        end else begin
            rise   = (c && !m_car_d) ? 1 : 0;
            zero   = (m_cnt == 0) ? 1 : 0;
            en     = (zero && !m_zero_d) ? 1 : 0;
            ld     = (int'(l) != m_len_d) ? 1 : 0;
            ld_out = q_ld.pop_front();
            en_out = q_en.pop_front();
            q_ld.push_back(ld);
            q_en.push_back(en);
            m_valid = (ld_out || en_out) ? 1 : 0;
            if (ld_out) m_lfsr = 31;
            else if (en_out) m_lfsr = lfsr_next(m_lfsr);
            if (rise) m_cnt = (m_cnt + 1) % 6;
            m_zero_d = zero;
            m_car_d  = c;
            m_len_d  = l;
        end
        @(posedge clk);
    endtask

    initial begin
        bit lvl;
        int last;
        int rec[$];
        int exp_s;
        int k;
        int seed;
        int quiet;

        lvl = 0;
        for (int i = 0; i < 4; i++) step(0, 0, 1);
        step(0, 0, 0);
        check(obs_code == 4'hF && !obs_valid, "R1 reset state", int'(obs_code), 15);

        // R2: steady carrier, period 4 clocks
        last = -1;
        for (int i = 0; i < 200; i++) begin
            step((i % 4) < 2, lvl, 0);
            if (obs_valid) begin
                if (last >= 0) check(cyc - last == 24, "R2 enable spacing", cyc - last, 24);
                last = cyc;
            end
        end
        for (int i = 0; i < 10; i++) step(0, lvl, 0);

        // R3 R4 R5: rising then falling length edge, carrier idle
        for (int e = 0; e < 2; e++) begin
            lvl = !lvl;
            step(0, lvl, 0);
            for (int j = 1; j <= 6; j++) begin
                step(0, lvl, 0);
                if (j < 6) check(!obs_valid, "R5 reload not early", int'(obs_valid), 0);
                else check(obs_valid && obs_code == 4'hF, "R3 R4 R5 reload on edge", int'(obs_code), 15);
            end
        end
        quiet = 1;
        for (int i = 0; i < 20; i++) begin
            step(0, lvl, 0);
            if (obs_valid) quiet = 0;
        end
        check(quiet == 1, "R3 steady level no reload", quiet, 1);

        // R6: full sequence after a reload, carrier period 2
        lvl = !lvl;
        k = 0;
        rec.delete();
        while (rec.size() < 32 && k < 1000) begin
            step(k % 2, lvl, 0);
            if (obs_valid) rec.push_back(int'(obs_code));
            k++;
        end
        check(rec.size() == 32, "R6 enable count", rec.size(), 32);
        exp_s = 31;
        foreach (rec[i]) begin
            check(rec[i] == (exp_s >> 1), "R6 code sequence", rec[i], exp_s >> 1);
            exp_s = lfsr_next(exp_s);
        end
        if (rec.size() == 32) check(rec[31] == 15, "R6 period 31", rec[31], 15);

        // R7: reload and enable collide at the register
        for (int n = 0; n < 3; n++) begin
            k = 0;
            while (!model_en_now() && k < 100) begin
                step(k % 2, lvl, 0);
                k++;
            end
            lvl = !lvl;
            step(k % 2, lvl, 0);
            k++;
            for (int j = 1; j <= 6; j++) begin
                step(k % 2, lvl, 0);
                k++;
            end
            check(obs_valid && obs_code == 4'hF, "R7 reload over enable", int'(obs_code), 15);
            for (int j = 0; j < 30; j++) step(0, lvl, 0);
        end

        // mixed traffic with one mid-run reset
        seed = 12345;
        begin
            bit c;
            int run;
            c = 0;
            run = 1;
            for (int i = 0; i < 3000; i++) begin
                seed = seed * 1103515245 + 12345;
                if (--run == 0) begin
                    c = !c;
                    run = 1 + ((seed >>> 16) & 3);
                end
                if (((seed >>> 8) & 63) == 0) lvl = !lvl;
                step(c, lvl, i >= 1500 && i < 1503);
                if (i == 1503) check(obs_code == 4'hF && !obs_valid, "R1 reset mid-run", int'(obs_code), 15);
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule